// File: doc/BRIEF.md
# Single-Row Cached DRAM Front End

This block sits in front of a small DRAM array and keeps a copy of one complete row in a fast row buffer. A register holds the row address of the last row read. A comparator checks every access against that register. A read that matches the buffered row is served from the buffer in one cycle and needs no row enable. A read that misses, issued with row enable, loads the addressed row into the buffer over a fixed number of cycles and then returns the selected column. While the load runs, a busy flag is raised.

Every write goes straight into the array. When the write row matches the buffered row, the matching buffer word is written as well, so the buffer stays coherent. The column address is transparent while the column-latch input is high; while that input is low, the block uses the column captured in the last cycle it was high. The output enable gates the read register onto the data outputs and does not depend on the other controls. Refresh requests step an internal row counter by one row per request. They can run in the same cycle as buffer reads and never disturb the buffered row. A refresh that arrives during a row load waits until the load has finished.

Top module: `rowcache_dram_fe`

## Requirements
- R1: After reset, `busy_o`, `rvalid_o`, `ref_ack_o` and `rdata_o` are 0, the buffered-row register is invalid, and so the first read with row enable is a miss.
- R2: A read (`sel_i`=1, `wr_en_i`=0) to the buffered row is a hit, whatever the value of `row_en_i`. In the next cycle `rvalid_o` is 1, the buffered word of the column is on `rdata_o`, and `busy_o` stays 0.
- R3: A read miss with `row_en_i`=1 raises `busy_o` for exactly MISS_CYCLES (default 3) cycles, starting the cycle after the request. In the cycle `busy_o` falls, `rvalid_o` is 1 with the array word. The row then becomes the buffered row, so a later read of it is a hit.
- R4: A read miss with `row_en_i`=0 is ignored. `busy_o` and `rvalid_o` stay 0, and the buffered row is unchanged.
- R5: A write (`sel_i`=1, `wr_en_i`=1) stores `wdata_i` in the array. If its row is the buffered row, the buffer word is updated too, and a later hit returns the new value. A write to another row leaves the buffer untouched.
- R6: With `col_latch_i`=1 the column is taken from `col_addr_i`. With `col_latch_i`=0 it is the value `col_addr_i` had in the last clock cycle in which `col_latch_i` was 1.
- R7: `rdata_o` is 0 while `out_en_i`=0. While `out_en_i`=1 it shows the last returned read word, which is held until the next read returns.
- R8: Each idle cycle with `refresh_req_i`=1 gives a one-cycle `ref_ack_o` in the next cycle. `ref_row_o` counts 0,1,2,... modulo ROWS. A hit read in the same cycle still completes, and the buffered row is kept.
- R9: A refresh request made in the cycle a miss starts, or during a load, is held back. Its `ref_ack_o` comes in the cycle after `busy_o` falls, never while `busy_o` is 1. Requests that are held back together merge into one.
- R10: Reads and writes presented while `busy_o`=1 are ignored, and the array is not modified.
- R11: After reset, array word (row r, column c) holds ((16·r + c) XOR 0xA5), truncated to the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select: this cycle carries an access |
| row_en_i | input | 1 | Row enable: allows a row load on a read miss |
| col_latch_i | input | 1 | Column latch: 1 = transparent, 0 = hold captured column |
| out_en_i | input | 1 | Output enable for `rdata_o` |
| wr_en_i | input | 1 | 1 = write access, 0 = read access |
| refresh_req_i | input | 1 | Refresh request, one row per cycle held high |
| row_addr_i | input | RAW | Row address |
| col_addr_i | input | CAW | Column address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, gated by `out_en_i` |
| rvalid_o | output | 1 | One-cycle pulse: new read word returned |
| busy_o | output | 1 | Row load in progress |
| ref_ack_o | output | 1 | One-cycle pulse: a refresh row was serviced |
| ref_row_o | output | RAW | Row serviced by the latest refresh |

## Verification
The assertions assume a well-formed input stream. Inputs are stable around each rising edge, row addresses lie below ROWS, and refresh requests are treated one per cycle, so several requests during one load count as a single deferred row. The bench drives every input on the falling edge and keeps addresses inside the default 8x8 array. It issues at most one refresh request per load window, which keeps the acknowledge sequence a clean count that can be predicted.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOAD = 1'b1
  } dfe_state_e;

  // Power-on content of one array word, before truncation to the data width.
  function automatic int seed_word(input int r, input int c);
    return ((r * 16) + c) ^ 'hA5;
  endfunction

  // Row that the refresh pointer moves to after row r.
  function automatic int next_row(input int r, input int rows);
    return (r + 1 >= rows) ? 0 : r + 1;
  endfunction

endpackage

// File: rtl/dfe_col_capture.sv
module dfe_col_capture #(
  parameter int CAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           latch_i,
  input  logic [CAW-1:0] col_i,
  output logic [CAW-1:0] col_o
);

  logic [CAW-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (latch_i) held_q <= col_i;
  end

  // Transparent while the latch input is high, frozen while it is low.
  assign col_o = latch_i ? col_i : held_q;

endmodule

// File: rtl/dfe_row_tag.sv
module dfe_row_tag #(
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [RAW-1:0] load_row_i,
  input  logic [RAW-1:0] row_i,
  output logic           hit_o
);

  logic           valid_q;
  logic [RAW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      last_q  <= load_row_i;
    end
  end

  assign hit_o = valid_q && (row_i == last_q);

endmodule

// File: rtl/dfe_refresh_sched.sv
module dfe_refresh_sched
  import dfe_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int RAW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_i,
  input  logic           block_i,
  output logic           fire_o,
  output logic           ack_o,
  output logic [RAW-1:0] row_o
);

  logic           pend_q;
  logic [RAW-1:0] ptr_q;
  logic           want_w;

  assign want_w = req_i || pend_q;
  assign fire_o = want_w && !block_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ptr_q  <= '0;
      ack_o  <= 1'b0;
      row_o  <= '0;
    end else begin
      pend_q <= want_w && block_i;
      ack_o  <= fire_o;
      if (fire_o) begin
        row_o <= ptr_q;
        ptr_q <= RAW'(next_row(int'(ptr_q), ROWS));
      end
    end
  end

endmodule

// File: rtl/rowcache_dram_fe.sv
module rowcache_dram_fe
  import dfe_pkg::*;
#(
  parameter int ROWS        = 8,
  parameter int COLS        = 8,
  parameter int DW          = 8,
  parameter int MISS_CYCLES = 3,
  localparam int RAW        = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CAW        = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_i,
  input  logic           row_en_i,
  input  logic           col_latch_i,
  input  logic           out_en_i,
  input  logic           wr_en_i,
  input  logic           refresh_req_i,
  input  logic [RAW-1:0] row_addr_i,
  input  logic [CAW-1:0] col_addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           rvalid_o,
  output logic           busy_o,
  output logic           ref_ack_o,
  output logic [RAW-1:0] ref_row_o
);

  localparam int CNTW = $clog2(MISS_CYCLES + 1);

  dfe_state_e     state_q;
  logic [CNTW-1:0] cnt_q;
  logic [RAW-1:0] ld_row_q;
  logic [CAW-1:0] ld_col_q;
  logic [DW-1:0]  rd_q;
  logic           rvalid_q;
  logic [DW-1:0]  mem_q    [ROWS][COLS];
  logic [DW-1:0]  rowbuf_q [COLS];

  // Named internal events, also watched by the checker.
  logic           idle_w;
  logic           tag_hit_w;
  logic           hit_w;
  logic           miss_start_w;
  logic           load_done_w;
  logic           wr_fire_w;
  logic           ref_fire_w;
  logic [CAW-1:0] col_eff_w;

  dfe_col_capture #(.CAW(CAW)) i_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch_i (col_latch_i),
    .col_i   (col_addr_i),
    .col_o   (col_eff_w)
  );

  dfe_row_tag #(.RAW(RAW)) i_tag (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_done_w),
    .load_row_i (ld_row_q),
    .row_i      (row_addr_i),
    .hit_o      (tag_hit_w)
  );

  dfe_refresh_sched #(.ROWS(ROWS), .RAW(RAW)) i_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (refresh_req_i),
    .block_i (busy_o || miss_start_w),
    .fire_o  (ref_fire_w),
    .ack_o   (ref_ack_o),
    .row_o   (ref_row_o)
  );

  assign idle_w       = (state_q == ST_IDLE);
  assign hit_w        = idle_w && sel_i && !wr_en_i && tag_hit_w;
  assign miss_start_w = idle_w && sel_i && !wr_en_i && !tag_hit_w && row_en_i;
  assign wr_fire_w    = idle_w && sel_i && wr_en_i;
  assign load_done_w  = (state_q == ST_LOAD) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ld_row_q <= '0;
      ld_col_q <= '0;
      rd_q     <= '0;
      rvalid_q <= 1'b0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem_q[r][c] <= DW'(seed_word(r, c));
      for (int c = 0; c < COLS; c++)
        rowbuf_q[c] <= '0;
    end else begin
      rvalid_q <= hit_w || load_done_w;
      if (hit_w)
        rd_q <= rowbuf_q[col_eff_w];

      if (miss_start_w) begin
        state_q  <= ST_LOAD;
        cnt_q    <= CNTW'(MISS_CYCLES - 1);
        ld_row_q <= row_addr_i;
        ld_col_q <= col_eff_w;
      end else if (state_q == ST_LOAD) begin
        if (load_done_w) begin
          state_q <= ST_IDLE;
          for (int c = 0; c < COLS; c++)
            rowbuf_q[c] <= mem_q[ld_row_q][c];
          rd_q <= mem_q[ld_row_q][ld_col_q];
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      if (wr_fire_w) begin
        mem_q[row_addr_i][col_eff_w] <= wdata_i;
        if (tag_hit_w)
          rowbuf_q[col_eff_w] <= wdata_i;
      end
    end
  end

  assign busy_o   = (state_q == ST_LOAD);
  assign rvalid_o = rvalid_q;
  assign rdata_o  = out_en_i ? rd_q : '0;

endmodule

// File: rtl/rowcache_dram_fe_chk.sv
module rowcache_dram_fe_chk
  import dfe_pkg::*;
#(
  parameter int ROWS        = 8,
  parameter int RAW         = 3,
  parameter int MISS_CYCLES = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sel_i,
  input logic           wr_en_i,
  input logic           row_en_i,
  input logic           busy_o,
  input logic           rvalid_o,
  input logic           ref_ack_o,
  input logic [RAW-1:0] ref_row_o,
  input logic           hit_w,
  input logic           miss_start_w
);

  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == 16'(MISS_CYCLES)));

  // R3
  load_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> rvalid_o);

  // R2
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |=> (rvalid_o && !busy_o));

  // R4
  no_ren_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !wr_en_i && !row_en_i && !hit_w && !busy_o) |=> !busy_o);

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!hit_w && !miss_start_w));

  // R9
  ref_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack_o |-> !busy_o);

  // R8
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ack_o && $past(ref_ack_o)) |->
      (ref_row_o == RAW'(next_row(int'($past(ref_row_o)), ROWS))));

endmodule

bind rowcache_dram_fe rowcache_dram_fe_chk #(
  .ROWS(ROWS), .RAW(RAW), .MISS_CYCLES(MISS_CYCLES)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_i        (sel_i),
  .wr_en_i      (wr_en_i),
  .row_en_i     (row_en_i),
  .busy_o       (busy_o),
  .rvalid_o     (rvalid_o),
  .ref_ack_o    (ref_ack_o),
  .ref_row_o    (ref_row_o),
  .hit_w        (hit_w),
  .miss_start_w (miss_start_w)
);

// File: tb/test_rowcache_dram_fe.sv
`timescale 1ns/1ps
module test_rowcache_dram_fe;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 0, ren = 0, cal = 1, oe = 1, we = 0, rreq = 0;
  logic [2:0] row = 0, col = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata;
  logic rvalid, busy, rack;
  logic [2:0] rrow;

  always #2.5 clk = ~clk;

  rowcache_dram_fe i_rowcache_dram_fe (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .row_en_i(ren), .col_latch_i(cal),
    .out_en_i(oe), .wr_en_i(we), .refresh_req_i(rreq), .row_addr_i(row),
    .col_addr_i(col), .wdata_i(wd), .rdata_o(rdata), .rvalid_o(rvalid),
    .busy_o(busy), .ref_ack_o(rack), .ref_row_o(rrow)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mem_m [8][8];

  typedef struct packed {
    logic       wr;
    logic [2:0] r;
    logic [2:0] c;
    logic [7:0] d;
    logic       hit;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 3'd2, 3'd3, 8'h00, 1'b0},
    '{1'b0, 3'd2, 3'd5, 8'h00, 1'b1},
    '{1'b1, 3'd2, 3'd5, 8'h3C, 1'b0},
    '{1'b0, 3'd2, 3'd5, 8'h00, 1'b1},
    '{1'b1, 3'd6, 3'd1, 8'h77, 1'b0},
    '{1'b0, 3'd2, 3'd1, 8'h00, 1'b1},
    '{1'b0, 3'd6, 3'd1, 8'h00, 1'b0},
    '{1'b0, 3'd6, 3'd7, 8'h00, 1'b1},
    '{1'b0, 3'd0, 3'd0, 8'h00, 1'b0},
    '{1'b0, 3'd7, 3'd7, 8'h00, 1'b0},
    '{1'b1, 3'd7, 3'd0, 8'hE1, 1'b0},
    '{1'b0, 3'd7, 3'd0, 8'h00, 1'b1}
  };

  function automatic logic [7:0] seed_m(input int r, input int c);
    logic [3:0] rn = 4'(r);
    logic [3:0] cn = 4'(c);
    return {rn, cn} ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Read with expected hit/miss; data comes from the bench model.
  task automatic do_read(input int r, input int c, input bit en, input bit exp_hit,
                         input string req);
    int n = 0;
    @(negedge clk);
    sel = 1; we = 0; ren = en; row = 3'(r); col = 3'(c);
    @(negedge clk);
    sel = 0; ren = 0;
    if (exp_hit) begin
      chk(rvalid == 1'b1 && busy == 1'b0, req, {rvalid, busy}, 2'b10);
      chk(rdata == mem_m[r][c], req, rdata, mem_m[r][c]);
    end else begin
      chk(busy == 1'b1, req, busy, 1);
      while (busy && n < 20) begin
        chk(rvalid == 1'b0, req, rvalid, 0);
        n++;
        @(negedge clk);
      end
      chk(n == 3, {req, " busy length"}, n, 3);
      chk(rvalid == 1'b1, req, rvalid, 1);
      chk(rdata == mem_m[r][c], req, rdata, mem_m[r][c]);
    end
  endtask

  task automatic do_write(input int r, input int c, input logic [7:0] d, input string req);
    @(negedge clk);
    sel = 1; we = 1; row = 3'(r); col = 3'(c); wd = d;
    @(negedge clk);
    sel = 0; we = 0;
    mem_m[r][c] = d;
    chk(busy == 1'b0 && rvalid == 1'b0, req, {busy, rvalid}, 0);
  endtask

  initial begin
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        mem_m[r][c] = seed_m(r, c);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && rvalid == 0 && rack == 0 && rdata == 0, "R1", {busy, rvalid, rack, rdata}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 first miss, R2 hits, R3 loads, R5 writes, R11 seeds.
    for (int i = 0; i < 12; i++) begin
      if (VECS[i].wr) do_write(int'(VECS[i].r), int'(VECS[i].c), VECS[i].d, "R5 write");
      else do_read(int'(VECS[i].r), int'(VECS[i].c), 1'b1, VECS[i].hit,
                   VECS[i].hit ? "R2/R5/R11 hit" : "R3/R11 miss");
    end

    // R4: miss without row enable ignored; buffered row 7 still hits.
    @(negedge clk);
    sel = 1; we = 0; ren = 0; row = 3'd3; col = 3'd2;
    @(negedge clk);
    sel = 0;
    chk(busy == 0 && rvalid == 0, "R4", {busy, rvalid}, 0);
    @(negedge clk);
    chk(busy == 0, "R4", busy, 0);
    do_read(7, 7, 1'b0, 1'b1, "R4/R2 hit without row enable");

    // R6: column latch held low uses captured column.
    @(negedge clk);
    cal = 1; col = 3'd4;
    @(negedge clk);
    cal = 0; col = 3'd2; sel = 1; we = 0; row = 3'd7;
    @(negedge clk);
    sel = 0;
    chk(rvalid == 1 && rdata == mem_m[7][4], "R6 captured", rdata, mem_m[7][4]);
    cal = 1;
    do_read(7, 2, 1'b0, 1'b1, "R6 transparent");

    // R7: output enable gating, value held.
    oe = 0;
    #1 chk(rdata == 8'h00, "R7 oe low", rdata, 0);
    @(negedge clk);
    oe = 1;
    #1 chk(rdata == mem_m[7][2], "R7 oe high", rdata, mem_m[7][2]);

    // R8: refresh alongside a hit read.
    @(negedge clk);
    sel = 1; we = 0; row = 3'd7; col = 3'd1; rreq = 1;
    @(negedge clk);
    sel = 0; rreq = 0;
    chk(rack == 1 && rrow == 3'd0, "R8 ack row0", {rack, rrow}, 4'b1000);
    chk(rvalid == 1 && rdata == mem_m[7][1], "R8 hit with refresh", rdata, mem_m[7][1]);
    @(negedge clk);
    chk(rack == 0, "R8 ack one cycle", rack, 0);
    rreq = 1;
    @(negedge clk);
    rreq = 0;
    chk(rack == 1 && rrow == 3'd1, "R8 ack row1", {rack, rrow}, 4'b1001);
    do_read(7, 3, 1'b0, 1'b1, "R8 buffered row kept");

    // R9: refresh colliding with a miss is deferred.
    begin
      int n = 0;
      @(negedge clk);
      sel = 1; we = 0; ren = 1; row = 3'd1; col = 3'd6; rreq = 1;
      @(negedge clk);
      sel = 0; ren = 0; rreq = 0;
      while (busy && n < 20) begin
        chk(rack == 0, "R9 no ack while busy", rack, 0);
        n++;
        @(negedge clk);
      end
      chk(n == 3 && rdata == mem_m[1][6], "R9/R3 load", rdata, mem_m[1][6]);
      chk(rack == 0, "R9 not yet", rack, 0);
      @(negedge clk);
      chk(rack == 1 && rrow == 3'd2, "R9 deferred ack", {rack, rrow}, 4'b1010);
    end

    // R10: write during busy ignored.
    @(negedge clk);
    sel = 1; we = 0; ren = 1; row = 3'd4; col = 3'd0;
    @(negedge clk);
    chk(busy == 1, "R10 load", busy, 1);
    sel = 1; we = 1; ren = 0; row = 3'd1; col = 3'd0; wd = 8'h99;
    @(negedge clk);
    sel = 0; we = 0;
    repeat (4) @(negedge clk);
    do_read(1, 0, 1'b1, 1'b0, "R10 array unchanged");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule